// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block holds the modem-side handshake state of a classic serial port controller. A five-bit control register, written from the internal register bus, drives four active-low handshake outputs (terminal ready, request to send and two general-purpose outputs) and a loopback enable level that the serial routing logic uses elsewhere. Bus decoding lives outside; the block sees one select per register plus shared write and read strobes.

On the status side, the four active-low modem input pins (clear to send, data set ready, ring, carrier detect) pass through a synchronizer. The register reports their present asserted levels in its upper nibble and four sticky change flags in its lower nibble. Three of the flags set on any level change; the ring flag sets only when ring indication ends. Reading the status register clears the flags, and the modem-status interrupt request is high whenever any flag is set.

Top module: `mdm_ctlsts`

## Requirements
- R1: When `sel_ctl` and `wr_en` are both high at a clock edge, the control register takes `wdata[4:0]`; `ctl_rdata` shows it in bits 4..0 with bits 7..5 zero. A write strobe with `sel_ctl` low leaves it unchanged.
- R2: `dtr_n`, `rts_n`, `out1_n` and `out2_n` are the complements of control bits 0, 1, 2 and 3.
- R3: `loop_en` equals control bit 4.
- R4: A high `rst` at a clock edge clears the control register and all change flags: after it `ctl_rdata` is 0, the four handshake outputs are 1, `loop_en` and `msi_req` are 0.
- R5: `sts_rdata` bits 7, 6, 5, 4 are the complements of `dcd_n`, `ri_n`, `dsr_n`, `cts_n` as sampled two clock edges earlier (two-stage synchronizer).
- R6: Status bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect) set at the edge after the corresponding synchronized level changes in either direction, i.e. three edges after the pin changes.
- R7: Status bit 2 sets only when `ri_n` goes from 0 to 1 (ring ending), with the same latency as R6; a 1-to-0 change of `ri_n` does not set it.
- R8: An edge with `sel_sts` and `rd_en` both high clears status bits 3..0, except that a change detected in that same cycle sets its flag anyway.
- R9: `msi_req` is high exactly when any of status bits 3..0 is set.
- R10: Status bits 3..0 hold their value while no read of the status register happens; `rd_en` with `sel_sts` low does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| sel_ctl | input | 1 | Control register selected |
| sel_sts | input | 1 | Status register selected |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 5 | Write data bits 4..0 |
| ctl_rdata | output | 8 | Control register read value |
| sts_rdata | output | 8 | Status register read value |
| cts_n | input | 1 | Clear to send pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Terminal ready output, active low |
| rts_n | output | 1 | Request to send output, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| loop_en | output | 1 | Serial loopback enable level |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
On every cycle the assertions check the write path into the control register, the inverted output mapping, the reset values, that a detected change lands in its flag, that a clean read empties the flags, that flags otherwise hold, and that the interrupt tracks the flags. Only the bench scenarios show the pin-to-status latency through the synchronizer, that asserting ring does not set the trailing-edge flag while releasing it does, and that a change arriving in the same cycle as a read survives it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  localparam int unsigned MDM_PINS = 4;
  localparam int unsigned CTS_I = 0;
  localparam int unsigned DSR_I = 1;
  localparam int unsigned RI_I  = 2;
  localparam int unsigned DCD_I = 3;

  typedef logic [MDM_PINS-1:0] pin_vec_t;

  // Change events from the previous and present asserted levels.
  // Ring reports only its trailing edge (asserted -> released).
  function automatic pin_vec_t mdm_events(input pin_vec_t now_act, input pin_vec_t old_act);
    pin_vec_t ev;
    ev = now_act ^ old_act;
    ev[RI_I] = old_act[RI_I] & ~now_act[RI_I];
    return ev;
  endfunction

  // Next value of the sticky flags: a read clears, a new event always sets.
  function automatic pin_vec_t mdm_flag_next(input pin_vec_t cur, input pin_vec_t ev, input logic clr);
    return (clr ? '0 : cur) | ev;
  endfunction

  function automatic logic [2*MDM_PINS-1:0] mdm_pack_status(input pin_vec_t act, input pin_vec_t flags);
    return {act, flags};
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
  parameter int unsigned CTL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q
);

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_stb) ctl_q <= wdata;
  end

endmodule

// File: rtl/mdm_sts_reg.sv
module mdm_sts_reg
  import mdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_vec_t act,
  input  logic     rd_stb,
  output pin_vec_t flags,
  output pin_vec_t ev
);

  pin_vec_t act_old;

  assign ev = mdm_events(act, act_old);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_old <= '0;
      flags   <= '0;
    end else begin
      act_old <= act;
      flags   <= mdm_flag_next(flags, ev, rd_stb);
    end
  end

endmodule

// File: rtl/mdm_ctlsts.sv
module mdm_ctlsts
  import mdm_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CTL_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_ctl,
  input  logic              sel_sts,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CTL_W-1:0]  wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic [DATA_W-1:0] sts_rdata,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              loop_en,
  output logic              msi_req
);

  localparam int unsigned LOOP_BIT = CTL_W - 1;
  localparam int unsigned PAD_W    = DATA_W - CTL_W;

  // Named internal events, brought out for the checker.
  logic     ctl_wr_stb;
  logic     sts_rd_stb;
  pin_vec_t ev_vec;

  logic [CTL_W-1:0] ctl_q;
  pin_vec_t         pins_raw;
  pin_vec_t         pins_sync;
  pin_vec_t         act;
  pin_vec_t         flags;

  assign ctl_wr_stb = sel_ctl & wr_en;
  assign sts_rd_stb = sel_sts & rd_en;

  mdm_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (ctl_wr_stb),
    .wdata  (wdata),
    .ctl_q  (ctl_q)
  );

  assign pins_raw[CTS_I] = cts_n;
  assign pins_raw[DSR_I] = dsr_n;
  assign pins_raw[RI_I]  = ri_n;
  assign pins_raw[DCD_I] = dcd_n;

  mdm_sync #(.WIDTH(MDM_PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_sync)
  );

  assign act = ~pins_sync;

  mdm_sts_reg u_sts (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .rd_stb (sts_rd_stb),
    .flags  (flags),
    .ev     (ev_vec)
  );

  assign ctl_rdata = {{PAD_W{1'b0}}, ctl_q};
  assign sts_rdata = DATA_W'(mdm_pack_status(act, flags));

  assign dtr_n   = ~ctl_q[0];
  assign rts_n   = ~ctl_q[1];
  assign out1_n  = ~ctl_q[2];
  assign out2_n  = ~ctl_q[3];
  assign loop_en = ctl_q[LOOP_BIT];
  assign msi_req = |flags;

endmodule

// File: rtl/mdm_ctlsts_chk.sv
module mdm_ctlsts_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_ctl,
  input logic       sel_sts,
  input logic       wr_en,
  input logic       rd_en,
  input logic [4:0] wdata,
  input logic [7:0] ctl_rdata,
  input logic [7:0] sts_rdata,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       loop_en,
  input logic       msi_req,
  input logic [3:0] ev_vec
);

  a_r1_ctl_write: assert property (@(posedge clk) disable iff (rst)
    (sel_ctl && wr_en) |=> (ctl_rdata == {3'b000, $past(wdata)}));

  a_r1_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel_ctl && wr_en) |=> $stable(ctl_rdata));

  a_r2_outputs_inverted: assert property (@(posedge clk) disable iff (rst)
    {out2_n, out1_n, rts_n, dtr_n} == ~ctl_rdata[3:0]);

  a_r3_loop_level: assert property (@(posedge clk) disable iff (rst)
    loop_en == ctl_rdata[4]);

  a_r4_reset_values: assert property (@(posedge clk)
    rst |=> (ctl_rdata == 8'h00 && sts_rdata[3:0] == 4'h0 && !msi_req && !loop_en));

  a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (ev_vec != 4'h0) |=> ((sts_rdata[3:0] & $past(ev_vec)) == $past(ev_vec)));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (sel_sts && rd_en && ev_vec == 4'h0) |=> (sts_rdata[3:0] == 4'h0));

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!(sel_sts && rd_en) && ev_vec == 4'h0) |=> $stable(sts_rdata[3:0]));

  a_r9_irq_tracks_flags: assert property (@(posedge clk) disable iff (rst)
    msi_req == (sts_rdata[3:0] != 4'h0));

endmodule

bind mdm_ctlsts mdm_ctlsts_chk chk_i (.*);

// File: tb/mdm_ctlsts_tb_top.sv
module mdm_ctlsts_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       sel_ctl = 1'b0, sel_sts = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] wdata = '0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic [7:0] ctl_rdata, sts_rdata;
  logic       dtr_n, rts_n, out1_n, out2_n, loop_en, msi_req;

  mdm_ctlsts dut_i (
    .clk(clk), .rst(rst), .sel_ctl(sel_ctl), .sel_sts(sel_sts),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .loop_en(loop_en), .msi_req(msi_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: pin samples per edge kept in a queue {dcd,ri,dsr,cts}.
  logic [3:0] hist[$];
  logic [4:0] m_ctl = '0;
  logic [3:0] m_flg = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins_now();
    return {dcd_n, ri_n, dsr_n, cts_n};
  endfunction

  // Advance one clock: update model from pre-edge inputs, wait, compare.
  task automatic tick();
    logic [3:0] lvl_new, lvl_old, ev;
    if (rst) begin
      m_ctl = '0;
      m_flg = '0;
      hist.delete();
      hist.push_back(4'hF); hist.push_back(4'hF); hist.push_back(4'hF);
    end else begin
      lvl_new = ~hist[hist.size()-2];
      lvl_old = ~hist[hist.size()-3];
      ev = lvl_new ^ lvl_old;
      ev[2] = lvl_old[2] & ~lvl_new[2];
      m_flg = ((sel_sts && rd_en) ? 4'h0 : m_flg) | ev;
      if (sel_ctl && wr_en) m_ctl = wdata;
      hist.push_back(pins_now());
      if (hist.size() > 4) void'(hist.pop_front());
    end
    @(posedge clk);
    #1;
    chk(ctl_rdata == {3'b000, m_ctl}, "R1 ctl_rdata", ctl_rdata, {3'b000, m_ctl});
    chk({out2_n, out1_n, rts_n, dtr_n} == ~m_ctl[3:0], "R2 handshake outs",
        {out2_n, out1_n, rts_n, dtr_n}, ~m_ctl[3:0]);
    chk(loop_en == m_ctl[4], "R3 loop_en", loop_en, m_ctl[4]);
    chk(sts_rdata[7:4] == ~hist[hist.size()-2], "R5 status levels",
        sts_rdata[7:4], ~hist[hist.size()-2]);
    chk({sts_rdata[3], sts_rdata[1:0]} == {m_flg[3], m_flg[1:0]}, "R6 change flags",
        sts_rdata[3:0], m_flg);
    chk(sts_rdata[2] == m_flg[2], "R7 ring trailing flag", sts_rdata[2], m_flg[2]);
    chk(msi_req == (m_flg != 0), "R9 msi_req", msi_req, m_flg != 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ctl_write(input logic [4:0] v, input logic sel);
    sel_ctl = sel; wr_en = 1'b1; wdata = v;
    tick();
    sel_ctl = 1'b0; wr_en = 1'b0;
  endtask

  task automatic sts_read(input logic sel);
    sel_sts = sel; rd_en = 1'b1;
    tick();
    sel_sts = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    hist.push_back(4'hF); hist.push_back(4'hF); hist.push_back(4'hF);
    rst = 1'b1;
    idle(3);
    chk(ctl_rdata == 8'h00 && dtr_n && rts_n && out1_n && out2_n && !loop_en && !msi_req,
        "R4 reset state", {ctl_rdata, dtr_n, rts_n, out1_n, out2_n}, 8'h00 << 4 | 4'hF);
    rst = 1'b0;
    idle(4);
    chk(sts_rdata == 8'h00, "R4 no flags after reset", sts_rdata, 0);

    // Control register writes.
    ctl_write(5'h1F, 1'b1);
    ctl_write(5'h0A, 1'b1);
    chk(ctl_rdata == 8'h0A && rts_n == 1'b0 && dtr_n == 1'b1, "R2 pattern 0A",
        ctl_rdata, 8'h0A);
    ctl_write(5'h15, 1'b0);
    chk(ctl_rdata == 8'h0A, "R1 unselected write ignored", ctl_rdata, 8'h0A);
    ctl_write(5'h10, 1'b1);
    chk(loop_en == 1'b1, "R3 loop set", loop_en, 1);

    // CTS change: flag after three edges.
    cts_n = 1'b0;
    idle(2);
    chk(sts_rdata[4] == 1'b1 && sts_rdata[0] == 1'b0, "R5 cts level before flag",
        sts_rdata, 8'h10);
    idle(1);
    chk(sts_rdata[0] == 1'b1 && msi_req, "R6 cts flag", sts_rdata, 8'h11);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk(sts_rdata[0] == 1'b1, "R10 read without select keeps flag", sts_rdata[0], 1);
    idle(3);
    sts_read(1'b1);
    chk(sts_rdata[3:0] == 4'h0 && !msi_req, "R8 read clears", sts_rdata[3:0], 0);

    // Ring asserted: no flag; released: flag.
    ri_n = 1'b0;
    idle(5);
    chk(sts_rdata[2] == 1'b0 && sts_rdata[6] == 1'b1, "R7 ring assert no flag", sts_rdata, 8'h50);
    ri_n = 1'b1;
    idle(3);
    chk(sts_rdata[2] == 1'b1, "R7 ring release flag", sts_rdata[2], 1);
    sts_read(1'b1);

    // DSR and DCD changes, then a read in the same cycle as a new event.
    dsr_n = 1'b0; dcd_n = 1'b0;
    idle(4);
    chk(sts_rdata[3:0] == 4'hA, "R6 dsr dcd flags", sts_rdata[3:0], 4'hA);
    cts_n = 1'b1;
    idle(2);
    sts_read(1'b1);
    chk(sts_rdata[3:0] == 4'h1, "R8 event wins over read", sts_rdata[3:0], 4'h1);
    sts_read(1'b1);

    // Mixed toggling.
    for (int k = 0; k < 40; k++) begin
      {dcd_n, ri_n, dsr_n, cts_n} = 4'(k * 7 + 3);
      if (k % 5 == 0) ctl_write(5'(k), 1'b1);
      if (k % 3 == 0) sts_read(1'b1); else tick();
    end
    dcd_n = 1'b1; ri_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b1;
    idle(5);

    // Reset mid-run.
    rst = 1'b1; tick(); rst = 1'b0;
    chk(ctl_rdata == 8'h00 && !msi_req, "R4 reset mid-run", ctl_rdata, 0);
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule